// File: doc/BRIEF.md
# Dual-Core Prioritizing Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of on-chip devices and steers each one to one of two processor cores in one of three severity classes. The classes are standard, critical and machine check, with machine check the most severe. Every core has one output line per class. It also has a two-bit code that names the most severe class now active on that core.

Beside the device sources, the block holds a bank of software-raised core-to-core interrupts. One core can post any of 32 standard or 32 critical requests, or a machine check, on its partner. Posting and removal both use write-one registers.

All configuration and status go through a single-cycle register write port with a combinational read path. Through it, software can:
- route each source to a class and a core, or disable it;
- read the raw source levels and the levels of the enabled sources;
- post, clear and read back the core-to-core requests.

Top module: `dual_core_irq_ctrl`

## Requirements
- R1: While `rst` is high and right after it falls, every class output and `irq_top` read 0. Every routing register reads 0, so every source is disabled, and no core-to-core request is pending.
- R2: The routing register of source s sits at address s, for s below NUM_SRC. Bits [1:0] hold the class: 00 disabled, 01 standard, 10 critical, 11 machine check. Bit 2 holds the target core, 0 or 1. A read returns these three bits with all upper bits zero.
- R3: Each of a core's class outputs is the OR of two terms. The first term covers every source that is high and routed to that core and class. The second term covers any pending core-to-core request of that class aimed at that core. A source routed as 00 affects no output.
- R4: A source level change seen before rising edge N, or a register write taken at edge N, shows on the outputs after edge N+1 and not before.
- R5: Sources are level-sensitive. When a source falls, its contribution to the outputs goes away with the same two-edge latency.
- R6: Writing to address 0x30+4t sets the standard core-to-core bits for target core t at every one bit of the data; zero bits have no effect. Writing to 0x31+4t clears the bits at every one. Reading 0x30+4t returns the pending standard bits for core t.
- R7: Critical core-to-core bits for target core t behave the same way: set at 0x32+4t, clear at 0x33+4t, read back at 0x32+4t.
- R8: Writing to address 0x38 sets a pending machine check on core t for each data bit t that is one. Writing to 0x39 clears them the same way. Reading 0x38 returns the two pending bits in [1:0].
- R9: `irq_top[2c+1:2c]` gives the most severe active class of core c: 3 for machine check, 2 for critical, 1 for standard, 0 for none. It changes in the same cycle as the class outputs.
- R10: Address 0x20 returns the captured level of every source, whatever its routing. Address 0x21 returns the same levels masked to the sources whose class is not 00.
- R11: A write to an unmapped address changes no routing, no pending request and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Level-sensitive device requests |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| irq_std | output | 2 | Standard interrupt, one bit per core |
| irq_crit | output | 2 | Critical interrupt, one bit per core |
| irq_mchk | output | 2 | Machine-check interrupt, one bit per core |
| irq_top | output | 4 | Most severe active class per core, two bits each |

## Verification
The bench probes the two-edge latency from one cycle before the expected change. A design with one register too few or too many would show the line early or late. It raises a source routed as disabled, and a design that forgot the enable would assert an output while the raw status still shows the level. It posts core-to-core bits, writes zero bits, and then clears the bits one at a time. A design that clears on zero data or sets the wrong target core would leave the wrong line high. It overlaps machine-check, critical and standard requests on one core. A design whose priority code is ordered wrongly would report a lesser class while a more severe one is active.

// File: rtl/dcic_pkg.sv
package dcic_pkg;

    localparam int NCORE  = 2;
    localparam int C2C_W  = 32;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_RAW      = 8'h20;
    localparam logic [ADDR_W-1:0] A_MASKED   = 8'h21;
    localparam logic [ADDR_W-1:0] A_C2C_BASE = 8'h30;
    localparam logic [ADDR_W-1:0] A_MCHK_SET = 8'h38;
    localparam logic [ADDR_W-1:0] A_MCHK_CLR = 8'h39;

    typedef enum logic [1:0] {
        CLS_OFF  = 2'b00,
        CLS_STD  = 2'b01,
        CLS_CRIT = 2'b10,
        CLS_MCHK = 2'b11
    } irq_class_e;

    typedef struct packed {
        logic       tgt;
        irq_class_e cls;
    } route_t;

    typedef struct packed {
        logic mchk;
        logic crit;
        logic std;
    } class_vec_t;

    function automatic logic [1:0] top_code(class_vec_t v);
        if (v.mchk)      return 2'd3;
        else if (v.crit) return 2'd2;
        else if (v.std)  return 2'd1;
        else             return 2'd0;
    endfunction

    function automatic logic [ADDR_W-1:0] c2c_addr(int tgt, int slot);
        return A_C2C_BASE + ADDR_W'(4 * tgt + slot);
    endfunction

endpackage

// File: rtl/dcic_route_regs.sv
module dcic_route_regs
    import dcic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_wr,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output route_t [NUM_SRC-1:0]        routes
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                routes[s] <= '{tgt: 1'b0, cls: CLS_OFF};
            end else if (cfg_wr && cfg_addr == ADDR_W'(s)) begin
                routes[s] <= route_t'(cfg_wdata[2:0]);
            end
        end
    end

    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr >= ADDR_W'(NUM_SRC)) |=> $stable(routes)); // R11

endmodule

// File: rtl/dcic_c2c_bank.sv
module dcic_c2c_bank
    import dcic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_wr,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [DATA_W-1:0]            cfg_wdata,
    output logic [NCORE-1:0][C2C_W-1:0]  std_pend,
    output logic [NCORE-1:0][C2C_W-1:0]  crit_pend,
    output logic [NCORE-1:0]             mchk_pend
);

    localparam int SLOT_STD_SET  = 0;
    localparam int SLOT_STD_CLR  = 1;
    localparam int SLOT_CRIT_SET = 2;
    localparam int SLOT_CRIT_CLR = 3;

    for (genvar t = 0; t < NCORE; t++) begin : g_tgt
        localparam logic [ADDR_W-1:0] A_SS = c2c_addr(t, SLOT_STD_SET);
        localparam logic [ADDR_W-1:0] A_SC = c2c_addr(t, SLOT_STD_CLR);
        localparam logic [ADDR_W-1:0] A_CS = c2c_addr(t, SLOT_CRIT_SET);
        localparam logic [ADDR_W-1:0] A_CC = c2c_addr(t, SLOT_CRIT_CLR);

        logic [C2C_W-1:0] std_set, std_clr, crit_set, crit_clr;

        always_comb begin
            std_set  = (cfg_wr && cfg_addr == A_SS) ? cfg_wdata[C2C_W-1:0] : '0;
            std_clr  = (cfg_wr && cfg_addr == A_SC) ? cfg_wdata[C2C_W-1:0] : '0;
            crit_set = (cfg_wr && cfg_addr == A_CS) ? cfg_wdata[C2C_W-1:0] : '0;
            crit_clr = (cfg_wr && cfg_addr == A_CC) ? cfg_wdata[C2C_W-1:0] : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                std_pend[t]  <= '0;
                crit_pend[t] <= '0;
            end else begin
                std_pend[t]  <= (std_pend[t]  | std_set)  & ~std_clr;
                crit_pend[t] <= (crit_pend[t] | crit_set) & ~crit_clr;
            end
        end

        AST_C2C_STD_SET: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_addr == A_SS) |=>
            ((std_pend[t] & $past(cfg_wdata[C2C_W-1:0])) == $past(cfg_wdata[C2C_W-1:0]))); // R6
        AST_C2C_STD_CLR: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_addr == A_SC) |=>
            ((std_pend[t] & $past(cfg_wdata[C2C_W-1:0])) == '0)); // R6
        AST_C2C_CRIT_SET: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_addr == A_CS) |=>
            ((crit_pend[t] & $past(cfg_wdata[C2C_W-1:0])) == $past(cfg_wdata[C2C_W-1:0]))); // R7
        AST_C2C_CRIT_CLR: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_addr == A_CC) |=>
            ((crit_pend[t] & $past(cfg_wdata[C2C_W-1:0])) == '0)); // R7
    end

    logic [NCORE-1:0] mchk_set, mchk_clr;

    always_comb begin
        mchk_set = (cfg_wr && cfg_addr == A_MCHK_SET) ? cfg_wdata[NCORE-1:0] : '0;
        mchk_clr = (cfg_wr && cfg_addr == A_MCHK_CLR) ? cfg_wdata[NCORE-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) mchk_pend <= '0;
        else     mchk_pend <= (mchk_pend | mchk_set) & ~mchk_clr;
    end

    AST_C2C_MCHK_CLR: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == A_MCHK_CLR) |=>
        ((mchk_pend & $past(cfg_wdata[NCORE-1:0])) == '0)); // R8

endmodule

// File: rtl/dcic_core_merge.sv
module dcic_core_merge
    import dcic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int CORE_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_q,
    input  route_t [NUM_SRC-1:0]  routes,
    input  logic [C2C_W-1:0]      std_pend,
    input  logic [C2C_W-1:0]      crit_pend,
    input  logic                  mchk_pend,
    output class_vec_t            cls_o,
    output logic [1:0]            top_o
);

    localparam logic TGT = 1'(CORE_ID);

    class_vec_t nxt;

    always_comb begin
        nxt = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_q[s] && routes[s].tgt == TGT) begin
                case (routes[s].cls)
                    CLS_STD:  nxt.std  = 1'b1;
                    CLS_CRIT: nxt.crit = 1'b1;
                    CLS_MCHK: nxt.mchk = 1'b1;
                    default:  ;
                endcase
            end
        end
        nxt.std  = nxt.std  | (|std_pend);
        nxt.crit = nxt.crit | (|crit_pend);
        nxt.mchk = nxt.mchk | mchk_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_o <= '0;
            top_o <= 2'd0;
        end else begin
            cls_o <= nxt;
            top_o <= top_code(nxt);
        end
    end

    AST_TOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (top_o == 2'd0) |-> (cls_o == '0)); // R9
    AST_TOP_MCHK: assert property (@(posedge clk) disable iff (rst)
        cls_o.mchk |-> (top_o == 2'd3)); // R9
    AST_TOP_CRIT: assert property (@(posedge clk) disable iff (rst)
        (cls_o.crit && !cls_o.mchk) |-> (top_o == 2'd2)); // R9

endmodule

// File: rtl/dual_core_irq_ctrl.sv
module dual_core_irq_ctrl
    import dcic_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_irq,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic [NCORE-1:0]     irq_std,
    output logic [NCORE-1:0]     irq_crit,
    output logic [NCORE-1:0]     irq_mchk,
    output logic [2*NCORE-1:0]   irq_top
);

    logic [NUM_SRC-1:0]           src_q;
    route_t [NUM_SRC-1:0]         routes;
    logic [NCORE-1:0][C2C_W-1:0]  std_pend;
    logic [NCORE-1:0][C2C_W-1:0]  crit_pend;
    logic [NCORE-1:0]             mchk_pend;
    class_vec_t [NCORE-1:0]       core_cls;
    logic [NCORE-1:0][1:0]        core_top;
    logic [NUM_SRC-1:0]           src_en;

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_irq;
    end

    dcic_route_regs #(.NUM_SRC(NUM_SRC)) i_route (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .routes    (routes)
    );

    dcic_c2c_bank i_c2c (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .std_pend  (std_pend),
        .crit_pend (crit_pend),
        .mchk_pend (mchk_pend)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        dcic_core_merge #(.NUM_SRC(NUM_SRC), .CORE_ID(c)) i_merge (
            .clk       (clk),
            .rst       (rst),
            .src_q     (src_q),
            .routes    (routes),
            .std_pend  (std_pend[c]),
            .crit_pend (crit_pend[c]),
            .mchk_pend (mchk_pend[c]),
            .cls_o     (core_cls[c]),
            .top_o     (core_top[c])
        );
        assign irq_std[c]  = core_cls[c].std;
        assign irq_crit[c] = core_cls[c].crit;
        assign irq_mchk[c] = core_cls[c].mchk;
    end

    assign irq_top = core_top;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
        assign src_en[s] = (routes[s].cls != CLS_OFF);
    end

    always_comb begin
        cfg_rdata = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (cfg_addr == ADDR_W'(s)) cfg_rdata = DATA_W'(routes[s]);
        end
        for (int t = 0; t < NCORE; t++) begin
            if (cfg_addr == c2c_addr(t, 0)) cfg_rdata = DATA_W'(std_pend[t]);
            if (cfg_addr == c2c_addr(t, 2)) cfg_rdata = DATA_W'(crit_pend[t]);
        end
        if (cfg_addr == A_RAW)      cfg_rdata = DATA_W'(src_q);
        if (cfg_addr == A_MASKED)   cfg_rdata = DATA_W'(src_q & src_en);
        if (cfg_addr == A_MCHK_SET) cfg_rdata = DATA_W'(mchk_pend);
    end

    AST_SRC_GONE: assert property (@(posedge clk) disable iff (rst)
        (src_q == '0 && std_pend == '0 && crit_pend == '0 && mchk_pend == '0)
        |=> (irq_std == '0 && irq_crit == '0 && irq_mchk == '0)); // R5

endmodule

// File: tb/test_dual_core_irq_ctrl.sv
`timescale 1ns/1ps
module test_dual_core_irq_ctrl;

    localparam int NSRC = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_irq = '0;
    logic            cfg_wr = 1'b0;
    logic [7:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic [1:0]      irq_std, irq_crit, irq_mchk;
    logic [3:0]      irq_top;

    int checks = 0;
    int failures = 0;

    logic [2:0]      m_route [NSRC];
    logic [NSRC-1:0] m_src;
    logic [31:0]     m_std [2];
    logic [31:0]     m_crit [2];
    logic [1:0]      m_mchk;

    always #2 clk = ~clk;

    dual_core_irq_ctrl #(.NUM_SRC(NSRC)) i_dual_core_irq_ctrl (
        .clk(clk), .rst(rst), .src_irq(src_irq),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_std(irq_std), .irq_crit(irq_crit),
        .irq_mchk(irq_mchk), .irq_top(irq_top)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cls(int c);
        logic [2:0] r = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (m_src[s] && m_route[s][2] == c[0]) begin
                case (m_route[s][1:0])
                    2'b01: r[0] = 1'b1;
                    2'b10: r[1] = 1'b1;
                    2'b11: r[2] = 1'b1;
                    default: ;
                endcase
            end
        end
        if (m_std[c] != 0)  r[0] = 1'b1;
        if (m_crit[c] != 0) r[1] = 1'b1;
        if (m_mchk[c])      r[2] = 1'b1;
        return r;
    endfunction

    function automatic logic [1:0] exp_top(logic [2:0] v);
        return v[2] ? 2'd3 : v[1] ? 2'd2 : v[0] ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [NSRC-1:0] exp_masked();
        logic [NSRC-1:0] r;
        for (int s = 0; s < NSRC; s++) r[s] = m_src[s] && (m_route[s][1:0] != 2'b00);
        return r;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NSRC; s++) m_route[s] = '0;
        m_src = '0;
        for (int t = 0; t < 2; t++) begin m_std[t] = '0; m_crit[t] = '0; end
        m_mchk = '0;
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a < NSRC) m_route[a] = d[2:0];
        for (int t = 0; t < 2; t++) begin
            if (a == 8'(8'h30 + 4*t)) m_std[t]  = m_std[t] | d;
            if (a == 8'(8'h31 + 4*t)) m_std[t]  = m_std[t] & ~d;
            if (a == 8'(8'h32 + 4*t)) m_crit[t] = m_crit[t] | d;
            if (a == 8'(8'h33 + 4*t)) m_crit[t] = m_crit[t] & ~d;
        end
        if (a == 8'h38) m_mchk = m_mchk | d[1:0];
        if (a == 8'h39) m_mchk = m_mchk & ~d[1:0];
    endtask

    task automatic set_src(logic [NSRC-1:0] v);
        @(negedge clk);
        src_irq = v;
        m_src = v;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic cfg_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic check_outputs(string req);
        for (int c = 0; c < 2; c++) begin
            logic [2:0] e = exp_cls(c);
            chk(req, 32'({irq_mchk[c], irq_crit[c], irq_std[c]}), 32'(e));
            chk(req, 32'(irq_top[2*c +: 2]), 32'(exp_top(e)));
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk("R1", 32'({irq_std, irq_crit, irq_mchk, irq_top}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 32'({irq_std, irq_crit, irq_mchk, irq_top}), 32'd0);
        cfg_read(8'h03, rd);  chk("R1", rd, 32'd0);
        cfg_read(8'h34, rd);  chk("R1", rd, 32'd0);
        cfg_read(8'h38, rd);  chk("R1", rd, 32'd0);

        // R2: routing readback with upper bits dropped
        cfg_write(8'h03, 32'hFFFF_FFF9);
        cfg_read(8'h03, rd);  chk("R2", rd, 32'd1);

        // R4: latency of a source change, R3 result
        @(negedge clk);
        src_irq[3] = 1'b1; m_src[3] = 1'b1;
        @(negedge clk);
        chk("R4", 32'(irq_std[0]), 32'd0);
        @(negedge clk);
        chk("R4", 32'(irq_std[0]), 32'd1);
        check_outputs("R3");

        // R5: level-sensitive release
        set_src('0);
        settle();
        chk("R5", 32'(irq_std[0]), 32'd0);
        check_outputs("R5");

        // R3 / R10: disabled source has no effect, raw shows it
        cfg_write(8'h05, 32'd0);
        set_src(16'h0028);
        settle();
        check_outputs("R3");
        cfg_read(8'h20, rd);  chk("R10", rd, 32'h0028);
        cfg_read(8'h21, rd);  chk("R10", rd, 32'h0008);

        // R9: priority on core 1
        cfg_write(8'h01, 32'h7);
        cfg_write(8'h02, 32'h6);
        cfg_write(8'h04, 32'h5);
        set_src(16'h0016);
        settle();
        chk("R9", 32'(irq_top[3:2]), 32'd3);
        check_outputs("R9");
        set_src(16'h0014);
        settle();
        chk("R9", 32'(irq_top[3:2]), 32'd2);
        set_src(16'h0010);
        settle();
        chk("R9", 32'(irq_top[3:2]), 32'd1);
        set_src('0);
        settle();
        check_outputs("R9");

        // R6: standard core-to-core for core 1
        cfg_write(8'h34, 32'h8000_0001);
        // R4: a write reaches the outputs after the following edge
        chk("R4", 32'(irq_std[1]), 32'd0);
        @(negedge clk);
        chk("R4", 32'(irq_std[1]), 32'd1);
        chk("R6", 32'(irq_std[0]), 32'd0);
        cfg_read(8'h34, rd);  chk("R6", rd, 32'h8000_0001);
        cfg_write(8'h34, 32'd0);
        cfg_write(8'h35, 32'h0000_0001);
        settle();
        cfg_read(8'h34, rd);  chk("R6", rd, 32'h8000_0000);
        chk("R6", 32'(irq_std[1]), 32'd1);
        cfg_write(8'h35, 32'h8000_0000);
        settle();
        chk("R6", 32'(irq_std[1]), 32'd0);

        // R7: critical core-to-core for core 0
        cfg_write(8'h32, 32'h0000_0100);
        settle();
        chk("R7", 32'(irq_crit), 32'b01);
        cfg_read(8'h32, rd);  chk("R7", rd, 32'h100);
        cfg_write(8'h33, 32'h0000_0100);
        settle();
        chk("R7", 32'(irq_crit), 32'b00);

        // R8: machine check on core 0
        cfg_write(8'h38, 32'h1);
        settle();
        chk("R8", 32'(irq_mchk), 32'b01);
        chk("R8", 32'(irq_top[1:0]), 32'd3);
        cfg_read(8'h38, rd);  chk("R8", rd, 32'h1);
        cfg_write(8'h39, 32'h1);
        settle();
        chk("R8", 32'(irq_mchk), 32'b00);

        // R11: unmapped writes
        cfg_write(8'h34, 32'h10);
        cfg_write(8'h1F, 32'h7);
        cfg_write(8'h40, 32'hFFFF_FFFF);
        cfg_write(8'h3A, 32'hFFFF_FFFF);
        settle();
        check_outputs("R11");
        cfg_read(8'h34, rd);  chk("R11", rd, 32'h10);
        cfg_read(8'h01, rd);  chk("R11", rd, 32'h7);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 3);
            case (op)
                0: cfg_write(8'($urandom_range(0, NSRC-1)), $urandom);
                1: set_src(NSRC'($urandom));
                2: cfg_write(8'(8'h30 + 4*$urandom_range(0, 1) + $urandom_range(0, 3)),
                             $urandom & $urandom & $urandom);
                default: cfg_write(8'(8'h38 + $urandom_range(0, 1)), 32'($urandom_range(0, 3)));
            endcase
            settle();
            check_outputs("R3");
            begin
                int s = $urandom_range(0, NSRC-1);
                cfg_read(8'(s), rd);  chk("R2", rd, 32'(m_route[s]));
            end
            cfg_read(8'h20, rd);  chk("R10", rd, 32'(m_src));
            cfg_read(8'h21, rd);  chk("R10", rd, 32'(exp_masked()));
            cfg_read(8'h30, rd);  chk("R6", rd, m_std[0]);
            cfg_read(8'h36, rd);  chk("R7", rd, m_crit[1]);
            cfg_read(8'h38, rd);  chk("R8", rd, 32'(m_mchk));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule